// File: doc/BRIEF.md
# Segmented Pipelined Add-and-Shift Datapath

This block adds, subtracts or passes through a wide two's-complement operand pair, then right-shifts the result arithmetically by zero, one or two places. The carry chain is split into fixed-width segments with a register between each pair. An operation therefore moves through the segments on a diagonal. Segment 0 finishes in the first cycle, and each higher segment finishes one cycle after the segment below it. Input slices are delayed into that diagonal on entry and delayed back out of it on exit, so the whole result appears at once. The block accepts a new operation on every clock.

A right shift pulls bits from the segment above into the top of each segment. Those bits belong to a sum that the upper segment has not yet formed. To supply them, each segment keeps its own small copy of the next segment's two low adder bits. That copy is fed by the lower segment's live carry-out. The top segment supplies the sign-extension bits itself. A controller that steers its loop on the low bits of a result can read them one cycle after issue. It does not have to wait for the full result.

Top module: `seg_addshift`

## Requirements
- R1: While rst_ni is low, res_o, lsb_o, valid_o and lsb_valid_o are all zero.
- R2: cmd_i = 01 selects addition. res_o is bits W-1..0 of (sign-extended a_i + sign-extended b_i), computed on W+2 bits and then arithmetically shifted right.
- R3: cmd_i = 10 selects subtraction (a_i - b_i), with the same widening, shifting and truncation as R2.
- R4: cmd_i = 00 and cmd_i = 11 both pass a_i through. b_i has no effect on res_o in either case.
- R5: shift_i = 00 applies no shift, 01 shifts right by one and 10 shifts right by two. Code 11 shifts right by two.
- R6: A carry or borrow leaving any segment reaches every higher segment, so the result is exact across all segment boundaries.
- R7: With a shift, the vacated top bits of each segment other than the top one are filled with the lowest sum bits of the segment above.
- R8: The vacated top bits of the top segment are filled with the sign of the W+1-bit true sum. Addition or subtraction overflow is therefore recovered by a shift.
- R9: res_o and valid_o show the operation issued S = W/SEG_W clocks earlier. Back-to-back operations on consecutive clocks do not interfere with each other.
- R10: lsb_o equals bits 1..0 of the result of the operation issued one clock earlier. lsb_valid_o carries that operation's valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Marks the operation on the inputs as meaningful |
| cmd_i | input | 2 | 00/11 pass, 01 add, 10 subtract |
| shift_i | input | 2 | 00 none, 01 by one, 10/11 by two |
| a_i | input | W | First operand, two's complement |
| b_i | input | W | Second operand, two's complement |
| valid_o | output | 1 | valid_i delayed by S clocks |
| res_o | output | W | Shifted result, S clocks after issue |
| lsb_valid_o | output | 1 | valid_i delayed by one clock |
| lsb_o | output | 2 | Low two result bits, one clock after issue |

## Verification
The hard case is a carry out of one segment and a shift across the same boundary in the same operation. The duplicated low-bit adder must then use a carry that is still being formed in that cycle. The bench provokes this with operands whose low segments are all ones, so a carry ripples into the next segment's lowest bits, combined with shifts by one and by two. It also provokes it with random operands and commands issued on every clock. Every cycle, the drained result and the early low bits are compared with a behavioural reference. That reference computes the whole operation on W+2-bit signed integers, with no notion of segments.

// File: rtl/seg_addshift_pkg.sv
package seg_addshift_pkg;
  typedef enum logic [1:0] {
    CMD_PASS  = 2'b00,
    CMD_ADD   = 2'b01,
    CMD_SUB   = 2'b10,
    CMD_PASS2 = 2'b11
  } cmd_e;

  // 11 behaves as shift-by-two
  function automatic logic [1:0] shift_amt(logic [1:0] code);
    return code[1] ? 2'd2 : (code[0] ? 2'd1 : 2'd0);
  endfunction
endpackage

// File: rtl/seg_addshift_dly.sv
module seg_addshift_dly #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] tap_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) tap_q[k] <= '0;
    end else begin
      tap_q[0] <= d_i;
      for (int k = 1; k < DEPTH; k++) tap_q[k] <= tap_q[k-1];
    end
  end

  assign q_o = tap_q[DEPTH-1];
endmodule

// File: rtl/seg_addshift_stage.sv
module seg_addshift_stage
  import seg_addshift_pkg::*;
#(
  parameter int SEG_W = 32,
  parameter bit FIRST = 1'b0,
  parameter bit LAST  = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEG_W-1:0] a_i,
  input  logic [SEG_W-1:0] b_i,
  input  logic [1:0]       nxt_a_i,
  input  logic [1:0]       nxt_b_i,
  input  logic [1:0]       cmd_i,
  input  logic [1:0]       shift_i,
  input  logic             cin_i,
  output logic [SEG_W-1:0] res_o,
  output logic             cout_o
);
  logic             is_add, is_sub, cin_eff, c_out;
  logic [SEG_W-1:0] bx, s_lo, res_d;
  logic [1:0]       na2, nb2, nbx2, nsum2, amt;
  logic [SEG_W+1:0] win;

  always_comb begin
    is_add  = (cmd_i == CMD_ADD);
    is_sub  = (cmd_i == CMD_SUB);
    bx      = is_sub ? ~b_i : (is_add ? b_i : '0);
    cin_eff = FIRST ? is_sub : cin_i;
    {c_out, s_lo} = {1'b0, a_i} + {1'b0, bx} + {{SEG_W{1'b0}}, cin_eff};
    // duplicate of the upper neighbour's two low sum bits; top stage uses sign extension
    nb2   = is_sub ? ~nxt_b_i : (is_add ? nxt_b_i : 2'b00);
    na2   = LAST ? {2{a_i[SEG_W-1]}} : nxt_a_i;
    nbx2  = LAST ? {2{bx[SEG_W-1]}}  : nb2;
    nsum2 = na2 + nbx2 + {1'b0, c_out};
    win   = {nsum2, s_lo};
    amt   = shift_amt(shift_i);
    case (amt)
      2'd1:    res_d = win[SEG_W:1];
      2'd2:    res_d = win[SEG_W+1:2];
      default: res_d = s_lo;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o  <= '0;
      cout_o <= 1'b0;
    end else begin
      res_o  <= res_d;
      cout_o <= c_out;
    end
  end

  AST_PASS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_add && !is_sub && amt == 2'd0 && !cin_eff) |=> (res_o == $past(a_i) && !cout_o))
    else $error("pass without shift altered slice"); // R4

  if (!FIRST) begin : g_mid
    AST_PASS_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!is_add && !is_sub) |-> !cin_i)
      else $error("carry arrived for a pass operation"); // R6
  end

  if (FIRST) begin : g_first
    AST_SUB_SELF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_sub && a_i == b_i && amt == 2'd0) |=> (res_o == '0 && cout_o))
      else $error("x - x not zero with carry"); // R3
  end

  if (LAST) begin : g_top
    AST_SIGN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!is_add && !is_sub) |=> (res_o[SEG_W-1] == $past(a_i[SEG_W-1])))
      else $error("sign lost on pass"); // R8
  end
endmodule

// File: rtl/seg_addshift.sv
module seg_addshift #(
  parameter int W     = 128,
  parameter int SEG_W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [1:0]   cmd_i,
  input  logic [1:0]   shift_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         valid_o,
  output logic [W-1:0] res_o,
  output logic         lsb_valid_o,
  output logic [1:0]   lsb_o
);
  localparam int S    = W / SEG_W;
  localparam int IN_W = 2 * SEG_W + 8;

  logic [S-1:0] carry;

  for (genvar i = 0; i < S; i++) begin : g_seg
    localparam int LO = i * SEG_W;
    logic [3:0]       nx_pk;
    logic [IN_W-1:0]  in_pk, in_sk;
    logic [SEG_W-1:0] a_sk, b_sk, r_st, r_al;
    logic [1:0]       na_sk, nb_sk, cmd_sk, sh_sk;

    if (i < S - 1) begin : g_nx
      assign nx_pk = {a_i[LO+SEG_W +: 2], b_i[LO+SEG_W +: 2]};
    end else begin : g_nx_top
      assign nx_pk = 4'b0;
    end

    assign in_pk = {nx_pk, cmd_i, shift_i, a_i[LO +: SEG_W], b_i[LO +: SEG_W]};

    if (i == 0) begin : g_in0
      assign in_sk = in_pk;
    end else begin : g_in
      seg_addshift_dly #(.WIDTH(IN_W), .DEPTH(i)) u_in_dly (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(in_pk), .q_o(in_sk));
    end

    assign {na_sk, nb_sk, cmd_sk, sh_sk, a_sk, b_sk} = in_sk;

    seg_addshift_stage #(
      .SEG_W(SEG_W), .FIRST(i == 0), .LAST(i == S - 1)
    ) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .a_i     (a_sk),
      .b_i     (b_sk),
      .nxt_a_i (na_sk),
      .nxt_b_i (nb_sk),
      .cmd_i   (cmd_sk),
      .shift_i (sh_sk),
      .cin_i   (carry[(i + S - 1) % S]), // ignored by the first stage
      .res_o   (r_st),
      .cout_o  (carry[i])
    );

    if (i == S - 1) begin : g_out_top
      assign r_al = r_st;
    end else begin : g_out
      seg_addshift_dly #(.WIDTH(SEG_W), .DEPTH(S - 1 - i)) u_out_dly (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(r_st), .q_o(r_al));
    end

    assign res_o[LO +: SEG_W] = r_al;

    if (i == 0) begin : g_lsb
      assign lsb_o = r_st[1:0];
    end
  end

  seg_addshift_dly #(.WIDTH(1), .DEPTH(S)) u_vld_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(valid_i), .q_o(valid_o));

  seg_addshift_dly #(.WIDTH(1), .DEPTH(1)) u_lsb_vld_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(valid_i), .q_o(lsb_valid_o));
endmodule

// File: tb/tb_seg_addshift.sv
module tb_seg_addshift;
  localparam int W          = 128;
  localparam int SEG_W      = 32;
  localparam int S          = W / SEG_W;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic         v;
    logic [W-1:0] r;
    string        tag;
  } ent_t;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   cmd_i = 2'b00;
  logic [1:0]   shift_i = 2'b00;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         valid_o, lsb_valid_o;
  logic [W-1:0] res_o;
  logic [1:0]   lsb_o;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;
  ent_t hist[$];

  seg_addshift #(.W(W), .SEG_W(SEG_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .cmd_i(cmd_i),
    .shift_i(shift_i), .a_i(a_i), .b_i(b_i), .valid_o(valid_o),
    .res_o(res_o), .lsb_valid_o(lsb_valid_o), .lsb_o(lsb_o));

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                         logic [1:0] c, logic [1:0] sh);
    logic signed [W+1:0] ea, eb, t;
    int amt;
    ea = {{2{a[W-1]}}, a};
    eb = {{2{b[W-1]}}, b};
    case (c)
      2'b01:   t = ea + eb;
      2'b10:   t = ea - eb;
      default: t = ea;
    endcase
    amt = sh[1] ? 2 : (sh[0] ? 1 : 0);
    t = t >>> amt;
    return t[W-1:0];
  endfunction

  function automatic logic [W-1:0] rnd_w();
    logic [W-1:0] x;
    for (int k = 0; k < W / 32; k++) x[k*32 +: 32] = $urandom;
    return x;
  endfunction

  task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare at negedge, then present the next operation
  task automatic step(logic v, logic [1:0] c, logic [1:0] sh,
                      logic [W-1:0] a, logic [W-1:0] b, string tag);
    ent_t e;
    @(negedge clk);
    chk(valid_o == hist[S-1].v, "R9 valid_o", W'(valid_o), W'(hist[S-1].v));
    chk(res_o == hist[S-1].r, hist[S-1].tag, res_o, hist[S-1].r);
    chk(lsb_valid_o == hist[0].v, "R10 lsb_valid_o", W'(lsb_valid_o), W'(hist[0].v));
    chk(lsb_o == hist[0].r[1:0], "R10 lsb_o", W'(lsb_o), W'(hist[0].r[1:0]));
    valid_i = v; cmd_i = c; shift_i = sh; a_i = a; b_i = b;
    e.v = v; e.r = model(a, b, c, sh); e.tag = tag;
    hist.push_front(e);
    if (hist.size() > S) void'(hist.pop_back());
  endtask

  initial begin
    logic [W-1:0] max_p, min_n, ones_lo, bnd;
    max_p   = {1'b0, {(W-1){1'b1}}};
    min_n   = {1'b1, {(W-1){1'b0}}};
    ones_lo = {{SEG_W{1'b0}}, {(W-SEG_W){1'b1}}};
    bnd     = '0;
    for (int k = 0; k < S; k++) bnd[k*SEG_W +: 2] = 2'b11;

    for (int k = 0; k < S; k++) begin
      ent_t z;
      z.v = 1'b0; z.r = '0; z.tag = "R1 res_o";
      hist.push_back(z);
    end

    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(res_o == '0, "R1 res_o", res_o, '0);
      chk(valid_o == 1'b0 && lsb_valid_o == 1'b0, "R1 valid", W'({valid_o, lsb_valid_o}), '0);
      chk(lsb_o == 2'b00, "R1 lsb_o", W'(lsb_o), '0);
    end
    rst_ni = 1'b1;

    step(1, 2'b01, 2'b00, W'(5), W'(7), "R2 add");
    step(1, 2'b01, 2'b01, W'(9), W'(4), "R2 add shift1");
    step(1, 2'b10, 2'b00, W'(0), W'(1), "R3 sub borrow");
    step(1, 2'b10, 2'b00, rnd_w(), W'(3), "R3 sub");
    step(1, 2'b10, 2'b10, W'(100), W'(3), "R3 sub shift2");
    step(1, 2'b00, 2'b00, W'(77), rnd_w(), "R4 pass 00");
    step(1, 2'b11, 2'b01, W'(77), rnd_w(), "R4 pass 11");
    step(1, 2'b00, 2'b11, W'(13), W'(0), "R5 code 11");
    step(1, 2'b00, 2'b10, W'(13), W'(0), "R5 code 10");
    step(1, 2'b01, 2'b00, ones_lo, W'(1), "R6 carry chain");
    step(1, 2'b10, 2'b00, ~ones_lo, W'(1), "R6 borrow chain");
    step(1, 2'b00, 2'b01, bnd, W'(0), "R7 shift1 boundary");
    step(1, 2'b00, 2'b10, bnd, W'(0), "R7 shift2 boundary");
    step(1, 2'b01, 2'b01, ones_lo, W'(1), "R7 carry+shift1");
    step(1, 2'b01, 2'b10, ones_lo, W'(3), "R7 carry+shift2");
    step(1, 2'b00, 2'b10, min_n, W'(0), "R8 sign fill");
    step(1, 2'b01, 2'b01, max_p, max_p, "R8 overflow add");
    step(1, 2'b01, 2'b01, min_n, min_n, "R8 underflow add");
    step(1, 2'b10, 2'b10, min_n, W'(1), "R8 underflow sub");
    step(1, 2'b10, 2'b01, max_p, min_n, "R8 overflow sub");

    for (int n = 0; n < 4000; n++) begin
      logic [W-1:0] a, b;
      a = rnd_w(); b = rnd_w();
      if (n % 5 == 0) a = ones_lo;
      if (n % 7 == 0) b = W'(1) << ($urandom % W);
      step(1'($urandom), 2'($urandom), 2'($urandom), a, b, "R9 random stream");
    end
    for (int n = 0; n < S + 2; n++) step(0, 2'b00, 2'b00, '0, '0, "R9 drain");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule